// File: doc/BRIEF.md
# Victim Retention Cache Bank

This block is one bank of a shared last-level cache. A set-associative primary array serves ordinary lookups. Behind it sits a pool of reserve lines that is shared by the whole bank. The pool is indexed by a fully associative side tag store with one entry per reserve line. When a fill pushes a block out of its set, the block is not dropped. It is parked in the reserve line that the side tag store marks as least recently used. A set under heavy pressure can therefore hold more live blocks than its own ways. Only a block pushed out of the reserve pool leaves the bank. Only that departure tells the private upper-level caches to drop their copies, and a dirty departing block is also written back.

Each request looks up the primary ways of the indexed set and the side tag store at the same time. A primary-way match is a direct hit and answers one cycle later. A side-store match is an indirect hit. It answers one cycle later than a direct hit because the reserve data is read in a second access. A request that matches neither is a miss. The bank reports the miss and then installs the block, reading the memory word for a read or taking the written word for a write. The bank serves one request at a time and drops ready while an indirect hit or a fill is pending.

Top module: `vrc_bank`

## Requirements
- R1: A read that matches a valid primary way gives rspValid one cycle after acceptance, with rspKind 2'b01 and the stored word on rspData.
- R2: A request that matches only the side tag store keeps reqReady low for one cycle. It then gives rspValid two cycles after acceptance with rspKind 2'b10 and the reserve word.
- R3: A request that matches nothing gives rspValid one cycle after acceptance with rspKind 2'b00. For a read, memRdValid then stays high with memRdAddr equal to the request address until memFillValid arrives. reqReady stays low until the cycle after the fill is taken.
- R4: A write that hits returns the written word and marks the line dirty. A write that misses allocates the line with the written word, marks it dirty and issues no memory read.
- R5: A fill into a full set replaces the least recently used primary way of that set, where recency is updated by every direct hit and every fill.
- R6: The replaced primary block moves into the reserve pool and is then reachable by indirect hits. This move alone raises neither invValid nor wbValid.
- R7: The reserve line that takes a new victim is the globally least recently used one. Recency is refreshed by every indirect hit and every insertion.
- R8: A block pushed out of the reserve pool raises invValid with its address for one cycle. It also raises wbValid with the same address and its data in that cycle if, and only if, it is dirty.
- R9: After reset the bank holds no valid line, reqReady is high, and rspValid, memRdValid, wbValid and invValid are low.
- R10: An indirect hit leaves the block in its reserve line, so a repeat request to it is again an indirect hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bank can accept a request this cycle |
| reqAddr | input | 32 | Word address; low 4 bits select the set |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write word |
| rspValid | output | 1 | Response strobe |
| rspKind | output | 2 | 00 miss, 01 direct hit, 10 indirect hit |
| rspData | output | 32 | Read word (or written word on a write hit) |
| memRdValid | output | 1 | Memory read for a read miss is pending |
| memRdAddr | output | 32 | Address of the pending memory read |
| memFillValid | input | 1 | Memory word is present |
| memFillData | input | 32 | Memory word |
| wbValid | output | 1 | Dirty block leaving the bank |
| wbAddr | output | 32 | Write-back address |
| wbData | output | 32 | Write-back word |
| invValid | output | 1 | Upper-level copies must be dropped |
| invAddr | output | 32 | Address to drop |

## Verification
Two things can happen on the same install edge: a victim is parked in the reserve pool, and the reserve's oldest block is pushed out, which must raise both the invalidate and, for dirty data, the write-back. The bench causes this by filling the pool with victims from one set, some of them written, and then missing once more in a full set. In a separate step it refreshes one old reserve block with an indirect hit just before the overflow. A behavioural queue model predicts which block departs, its address and dirtiness, and whether a write-back is due. The bench compares those predictions with the ports in the cycle right after the fill edge and checks every other cycle for silence.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [1:0] {
    KIND_MISS     = 2'b00,
    KIND_DIRECT   = 2'b01,
    KIND_INDIRECT = 2'b10
  } hitKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_IND,
    ST_FILL
  } vrcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic indFinish;  // second array access of an indirect hit
    logic install;    // fill the pending block now
  } vrcStrobe_t;
endpackage

// File: rtl/vrc_age_lru.sv
// True LRU over N entries kept as distinct ages; age N-1 is the oldest.
module vrc_age_lru #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          touch,
  input  logic [IW-1:0] touchIdx,
  output logic [IW-1:0] lruIdx
);
  logic [IW-1:0] age [N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < N; j++) age[j] <= IW'(N - 1 - j);
    end else if (touch) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) == touchIdx)          age[j] <= '0;
        else if (age[j] < age[touchIdx]) age[j] <= age[j] + 1'b1;
      end
    end
  end

  always_comb begin
    lruIdx = '0;
    for (int j = 0; j < N; j++)
      if (age[j] == IW'(N - 1)) lruIdx = IW'(j);
  end
endmodule

// File: rtl/vrc_ctrl.sv
module vrc_ctrl
  import vrc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       dirHit,
  input  logic       indHit,
  input  logic       pendWrite,
  input  logic       memFillValid,
  output logic       reqReady,
  output logic       memRdValid,
  output vrcStrobe_t ctl
);
  vrcState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl        = '0;
    nextState  = state;
    reqReady   = (state == ST_IDLE);
    memRdValid = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.accept = 1'b1;
        if (!dirHit && indHit) nextState = ST_IND;
        else if (!dirHit)      nextState = ST_FILL;
      end
      ST_IND: begin
        ctl.indFinish = 1'b1;
        nextState     = ST_IDLE;
      end
      ST_FILL: begin
        memRdValid = !pendWrite;
        if (pendWrite || memFillValid) begin
          ctl.install = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R3: a memory read is only outstanding while the bank is closed
  a_r3_memrd_closed: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !reqReady);

  // R2: an accepted side-store-only match is finished on the next edge
  a_r2_ind_second_access: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accept && indHit && !dirHit) |=> (ctl.indFinish && !reqReady));
endmodule

// File: rtl/vrc_datapath.sv
module vrc_datapath
  import vrc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int SPARE  = 1,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  vrcStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memFillData,
  output logic              dirHit,
  output logic              indHit,
  output logic              pendWrite,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              rspValid,
  output logic [1:0]        rspKind,
  output logic [DATA_W-1:0] rspData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              invValid,
  output logic [ADDR_W-1:0] invAddr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int RES   = SETS * SPARE;
  localparam int RES_W = $clog2(RES);

  // primary array
  logic [TAG_W-1:0]  normTag   [SETS][WAYS];
  logic [DATA_W-1:0] normData  [SETS][WAYS];
  logic              normValid [SETS][WAYS];
  logic              normDirty [SETS][WAYS];
  // reserve pool and its fully associative tag store
  logic [ADDR_W-1:0] resAddr  [RES];
  logic [DATA_W-1:0] resData  [RES];
  logic              resValid [RES];
  logic              resDirty [RES];

  // pending request
  logic [ADDR_W-1:0] pAddr;
  logic [DATA_W-1:0] pWdata;
  logic              pWrite;
  logic [RES_W-1:0]  pResIdx;

  logic [IDX_W-1:0] idx, pIdx;
  logic [TAG_W-1:0] tag, pTag;
  logic [WAY_W-1:0] dirWay;
  logic [RES_W-1:0] indIdx;

  assign idx       = reqAddr[IDX_W-1:0];
  assign tag       = reqAddr[ADDR_W-1:IDX_W];
  assign pIdx      = pAddr[IDX_W-1:0];
  assign pTag      = pAddr[ADDR_W-1:IDX_W];
  assign pendWrite = pWrite;
  assign memRdAddr = pAddr;

  // parallel lookup: primary ways of the set and the whole side store
  always_comb begin
    dirHit = 1'b0;
    dirWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (normValid[idx][w] && normTag[idx][w] == tag) begin
        dirHit = 1'b1;
        dirWay = WAY_W'(w);
      end
  end

  always_comb begin
    indHit = 1'b0;
    indIdx = '0;
    for (int r = 0; r < RES; r++)
      if (resValid[r] && resAddr[r] == reqAddr) begin
        indHit = 1'b1;
        indIdx = RES_W'(r);
      end
  end

  // replacement state
  logic [WAY_W-1:0] lruWay [SETS];
  logic [WAY_W-1:0] vWay;
  logic             vValid;
  logic [RES_W-1:0] resLru;
  logic             resTouch;
  logic [RES_W-1:0] resTouchIdx;

  assign vWay   = lruWay[pIdx];
  assign vValid = normValid[pIdx][vWay];

  for (genvar s = 0; s < SETS; s++) begin : g_setLru
    logic             touchS;
    logic [WAY_W-1:0] tIdx;
    assign touchS = (ctl.accept && dirHit && (idx == IDX_W'(s))) ||
                    (ctl.install && (pIdx == IDX_W'(s)));
    assign tIdx   = ctl.install ? vWay : dirWay;
    vrc_age_lru #(.N(WAYS)) u_lru (
      .clk      (clk),
      .rstN     (rstN),
      .touch    (touchS),
      .touchIdx (tIdx),
      .lruIdx   (lruWay[s])
    );
  end

  assign resTouch    = ctl.indFinish || (ctl.install && vValid);
  assign resTouchIdx = ctl.indFinish ? pResIdx : resLru;

  vrc_age_lru #(.N(RES)) u_resLru (
    .clk      (clk),
    .rstN     (rstN),
    .touch    (resTouch),
    .touchIdx (resTouchIdx),
    .lruIdx   (resLru)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          normTag[s][w]   <= '0;
          normData[s][w]  <= '0;
          normValid[s][w] <= 1'b0;
          normDirty[s][w] <= 1'b0;
        end
      for (int r = 0; r < RES; r++) begin
        resAddr[r]  <= '0;
        resData[r]  <= '0;
        resValid[r] <= 1'b0;
        resDirty[r] <= 1'b0;
      end
      pAddr    <= '0;
      pWdata   <= '0;
      pWrite   <= 1'b0;
      pResIdx  <= '0;
      rspValid <= 1'b0;
      rspKind  <= KIND_MISS;
      rspData  <= '0;
      wbValid  <= 1'b0;
      wbAddr   <= '0;
      wbData   <= '0;
      invValid <= 1'b0;
      invAddr  <= '0;
    end else begin
      rspValid <= 1'b0;
      wbValid  <= 1'b0;
      invValid <= 1'b0;

      if (ctl.accept) begin
        pAddr   <= reqAddr;
        pWdata  <= reqWdata;
        pWrite  <= reqWrite;
        pResIdx <= indIdx;
        if (dirHit) begin
          rspValid <= 1'b1;
          rspKind  <= KIND_DIRECT;
          rspData  <= reqWrite ? reqWdata : normData[idx][dirWay];
          if (reqWrite) begin
            normData[idx][dirWay]  <= reqWdata;
            normDirty[idx][dirWay] <= 1'b1;
          end
        end else if (!indHit) begin
          rspValid <= 1'b1;
          rspKind  <= KIND_MISS;
          rspData  <= '0;
        end
      end

      if (ctl.indFinish) begin
        rspValid <= 1'b1;
        rspKind  <= KIND_INDIRECT;
        rspData  <= pWrite ? pWdata : resData[pResIdx];
        if (pWrite) begin
          resData[pResIdx]  <= pWdata;
          resDirty[pResIdx] <= 1'b1;
        end
      end

      if (ctl.install) begin
        if (vValid) begin
          if (resValid[resLru]) begin
            invValid <= 1'b1;
            invAddr  <= resAddr[resLru];
            if (resDirty[resLru]) begin
              wbValid <= 1'b1;
              wbAddr  <= resAddr[resLru];
              wbData  <= resData[resLru];
            end
          end
          resAddr[resLru]  <= {normTag[pIdx][vWay], pIdx};
          resData[resLru]  <= normData[pIdx][vWay];
          resDirty[resLru] <= normDirty[pIdx][vWay];
          resValid[resLru] <= 1'b1;
        end
        normTag[pIdx][vWay]   <= pTag;
        normData[pIdx][vWay]  <= pWrite ? pWdata : memFillData;
        normDirty[pIdx][vWay] <= pWrite;
        normValid[pIdx][vWay] <= 1'b1;
      end
    end
  end

  // R6: a block is never reachable through both lookups at once
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dirHit && indHit));

  // R6: invalidations only follow an install edge
  a_r6_inv_after_install: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> $past(ctl.install));

  // R8: a write-back always travels with an invalidate of the same block
  a_r8_wb_with_inv: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (invValid && invAddr == wbAddr));

  // R1: an accepted direct hit answers on the next cycle
  a_r1_direct_next: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accept && dirHit) |=> (rspValid && rspKind == KIND_DIRECT));
endmodule

// File: rtl/vrc_bank.sv
module vrc_bank
  import vrc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int SPARE  = 1,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [1:0]        rspKind,
  output logic [DATA_W-1:0] rspData,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memFillValid,
  input  logic [DATA_W-1:0] memFillData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              invValid,
  output logic [ADDR_W-1:0] invAddr
);
  vrcStrobe_t ctl;
  logic       dirHit, indHit, pendWrite;

  vrc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .dirHit       (dirHit),
    .indHit       (indHit),
    .pendWrite    (pendWrite),
    .memFillValid (memFillValid),
    .reqReady     (reqReady),
    .memRdValid   (memRdValid),
    .ctl          (ctl)
  );

  vrc_datapath #(
    .SETS(SETS), .WAYS(WAYS), .SPARE(SPARE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqWdata    (reqWdata),
    .memFillData (memFillData),
    .dirHit      (dirHit),
    .indHit      (indHit),
    .pendWrite   (pendWrite),
    .memRdAddr   (memRdAddr),
    .rspValid    (rspValid),
    .rspKind     (rspKind),
    .rspData     (rspData),
    .wbValid     (wbValid),
    .wbAddr      (wbAddr),
    .wbData      (wbData),
    .invValid    (invValid),
    .invAddr     (invAddr)
  );
endmodule

// File: tb/vrc_bank_tb.sv
module vrc_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam int RES  = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [1:0]  rspKind;
  logic [31:0] rspData;
  logic        memRdValid;
  logic [31:0] memRdAddr;
  logic        memFillValid = 1'b0;
  logic [31:0] memFillData = '0;
  logic        wbValid;
  logic [31:0] wbAddr, wbData;
  logic        invValid;
  logic [31:0] invAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrc_bank dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspKind(rspKind), .rspData(rspData),
    .memRdValid(memRdValid), .memRdAddr(memRdAddr),
    .memFillValid(memFillValid), .memFillData(memFillData),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .invValid(invValid), .invAddr(invAddr)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    bit          dirty;
  } line_t;

  // reference model: per-set queues and one reserve queue, MRU at the front
  line_t setQ [SETS][$];
  line_t resQ [$];
  logic [31:0] mem [logic [31:0]];

  int nChecks = 0;
  int nFail   = 0;
  int lastKind;
  bit lastInv;
  logic [31:0] lastInvAddr;
  bit summaryDone = 0;

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet(string req);
    chk(req, "wbValid idle", {31'b0, wbValid}, 32'd0);
    chk(req, "invValid idle", {31'b0, invValid}, 32'd0);
  endtask

  // entered and left at a falling edge
  task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd, input int lat);
    int s = int'(a[3:0]);
    int kind = 0;
    logic [31:0] expData = '0;
    bit hasVic = 0;
    bit hasLeave = 0;
    line_t ln, lv, nl;
    for (int k = 0; k < setQ[s].size(); k++)
      if (setQ[s][k].addr == a) begin
        kind = 1; ln = setQ[s][k]; setQ[s].delete(k); break;
      end
    if (kind == 0)
      for (int k = 0; k < resQ.size(); k++)
        if (resQ[k].addr == a) begin
          kind = 2; ln = resQ[k]; resQ.delete(k); break;
        end
    if (kind != 0) begin
      if (wr) begin ln.data = wd; ln.dirty = 1; end
      expData = ln.data;
      if (kind == 1) setQ[s].push_front(ln); else resQ.push_front(ln);
    end else begin
      nl.addr = a; nl.data = wr ? wd : memRead(a); nl.dirty = wr;
      if (setQ[s].size() == WAYS) begin
        line_t vic;
        vic = setQ[s].pop_back();
        hasVic = 1;
        if (resQ.size() == RES) begin lv = resQ.pop_back(); hasLeave = 1; end
        resQ.push_front(vic);
      end
      setQ[s].push_front(nl);
    end
    lastKind = kind; lastInv = hasLeave; lastInvAddr = lv.addr;

    chk("R3", "reqReady before issue", {31'b0, reqReady}, 32'd1);
    reqValid = 1; reqAddr = a; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    if (kind == 1) begin
      chk("R1", "direct rspValid", {31'b0, rspValid}, 32'd1);
      chk("R1", "direct rspKind", {30'b0, rspKind}, 32'd1);
      chk(wr ? "R4" : "R1", "direct rspData", rspData, expData);
      quiet("R6");
    end else if (kind == 2) begin
      chk("R2", "indirect gap rspValid", {31'b0, rspValid}, 32'd0);
      chk("R2", "indirect gap reqReady", {31'b0, reqReady}, 32'd0);
      @(negedge clk);
      chk("R2", "indirect rspValid", {31'b0, rspValid}, 32'd1);
      chk("R2", "indirect rspKind", {30'b0, rspKind}, 32'd2);
      chk("R2", "indirect rspData", rspData, expData);
      chk("R2", "indirect reqReady after", {31'b0, reqReady}, 32'd1);
      quiet("R6");
    end else begin
      chk("R3", "miss rspValid", {31'b0, rspValid}, 32'd1);
      chk("R3", "miss rspKind", {30'b0, rspKind}, 32'd0);
      chk("R3", "miss reqReady", {31'b0, reqReady}, 32'd0);
      chk(wr ? "R4" : "R3", "memRdValid", {31'b0, memRdValid}, {31'b0, !wr});
      if (!wr) begin
        chk("R3", "memRdAddr", memRdAddr, a);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk("R3", "memRdValid waiting", {31'b0, memRdValid}, 32'd1);
          chk("R3", "reqReady waiting", {31'b0, reqReady}, 32'd0);
          chk("R3", "rspValid waiting", {31'b0, rspValid}, 32'd0);
        end
        memFillValid = 1; memFillData = memRead(a);
      end
      quiet("R6");
      @(negedge clk);
      memFillValid = 0;
      chk("R3", "reqReady after fill", {31'b0, reqReady}, 32'd1);
      chk(hasVic ? "R8" : "R6", "invValid", {31'b0, invValid}, {31'b0, hasLeave});
      chk("R8", "wbValid", {31'b0, wbValid}, {31'b0, hasLeave && lv.dirty});
      if (hasLeave) begin
        chk("R7", "invAddr", invAddr, lv.addr);
        if (lv.dirty) begin
          chk("R8", "wbAddr", wbAddr, lv.addr);
          chk("R8", "wbData", wbData, lv.data);
          mem[lv.addr] = lv.data;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    if (!summaryDone) $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reqReady in reset", {31'b0, reqReady}, 32'd1);
    chk("R9", "rspValid in reset", {31'b0, rspValid}, 32'd0);
    chk("R9", "memRdValid in reset", {31'b0, memRdValid}, 32'd0);
    quiet("R9");
    rstN = 1;
    @(negedge clk);

    access(32'h100, 0, 0, 2);
    chk("R9", "first access after reset is a miss", lastKind, 0);
    access(32'h100, 0, 0, 0);
    access(32'h100, 1, 32'hDEAD_0001, 0);
    access(32'h100, 0, 0, 0);
    access(32'h110, 1, 32'hBEEF_0110, 0);
    chk("R4", "write miss allocates", lastKind, 0);
    access(32'h110, 0, 0, 0);
    chk("R4", "write-miss line then direct", lastKind, 1);
    access(32'h120, 0, 0, 1);
    access(32'h130, 0, 0, 0);
    access(32'h100, 0, 0, 0);
    access(32'h110, 0, 0, 0);
    access(32'h120, 0, 0, 0);
    // LRU of set 0 is now 0x130
    access(32'h140, 0, 0, 3);
    access(32'h130, 0, 0, 0);
    chk("R5", "LRU way went to reserve", lastKind, 2);
    chk("R6", "victim reachable indirectly", lastKind, 2);
    access(32'h130, 1, 32'hCAFE_0130, 0);
    chk("R10", "stays in reserve after indirect hit", lastKind, 2);
    access(32'h100, 0, 0, 0);
    chk("R5", "recent way kept", lastKind, 1);

    // fill the reserve from set 5; first victim 0x205 is dirty
    for (int k = 0; k < 19; k++)
      access(32'h205 + 32'(k) * 32'h10, (k % 2) == 0, 32'hA500_0000 + 32'(k), k % 3);
    access(32'h130, 0, 0, 0);
    chk("R7", "refreshed reserve block still held", lastKind, 2);
    access(32'h205 + 32'd19 * 32'h10, 0, 0, 1);
    chk("R7", "oldest reserve block leaves", {31'b0, lastInv}, 32'd1);
    chk("R7", "departing block is global LRU", lastInvAddr, 32'h205);
    access(32'h130, 0, 0, 0);
    chk("R7", "refreshed block survives", lastKind, 2);
    access(32'h205, 0, 0, 0);
    chk("R8", "written-back word returns from memory", lastKind, 0);

    for (int n = 0; n < 500; n++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      access(32'h1000 + {25'b0, lfsr[6:4], 4'b0} + {28'b0, lfsr[3:0]},
             lfsr[9:8] == 2'b00, lfsr ^ 32'h0F0F_0000, int'(lfsr[12:11]));
    end

    repeat (2) @(negedge clk);
    quiet("R8");
    summaryDone = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule